// File: doc/BRIEF.md
# ADC Result Byte-Read Bank

This block stores the most recent 10-bit conversion result of each of eight analog channels and lets an 8-bit processor bus read them. A converter deposits each result through a dedicated write port (channel index, data, strobe). The bus sees nine byte-wide registers: one low-byte register per channel and one high-byte register that all channels share.

A 10-bit value cannot cross the bus in one access, so a coherent read is built into the block. Reading a channel's low byte also copies that channel's two upper result bits into a small holding register. The shared high-byte register shows that holding register. Software reads the low byte first and then the high byte, and the two bytes always come from the same conversion, even if the converter writes a fresh result in between. The result storage has no reset, so its values survive a reset. The holding register and the read-data register are cleared by reset.

Top module: `adc_result_bank`

## Requirements
- R1: Bus address n (0..7) is the low-byte register of channel n. A read there returns bits 7..0 of the last result written to channel n. The value appears on `bus_rdata` in the clock cycle after the read strobe.
- R2: A read of any low-byte register copies bits 9..8 of that channel's result into the holding register at the same clock edge.
- R3: Bus address 8 is the shared high-byte register. A read there returns the holding register in bits 1..0, and bits 7..2 are zero.
- R4: A read of the high-byte register leaves the holding register unchanged.
- R5: A result write to any channel, including the channel just read, leaves the holding register unchanged.
- R6: A bus access with `bus_we` = 1 is a write and has no effect, even when `bus_rd` is also high. Result storage, the holding register and `bus_rdata` all keep their values.
- R7: A synchronous active-high reset clears the holding register and `bus_rdata` to zero. The stored results are not reset and keep their values across it.
- R8: When a result write and a low-byte read hit the same channel in the same cycle, the read returns the value that was stored before that cycle, and the following read returns the new value.
- R9: A read of addresses 9..15 returns zero and leaves the holding register unchanged.
- R10: `bus_rdata` holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_we | input | 1 | Result write strobe from the converter |
| res_ch | input | 3 | Channel of the result being written |
| res_data | input | 10 | Conversion result |
| bus_rd | input | 1 | Bus read strobe |
| bus_we | input | 1 | Bus write strobe (writes are ignored) |
| bus_addr | input | 4 | Register address |
| bus_rdata | output | 8 | Registered read data |

## Verification
The hardest case to reach is a converter write that lands between the low-byte read and the high-byte read of the same channel. In that case the high byte must still come from the older result. The bench brings this about by reading a low byte, writing a result with different upper bits to that channel, and then reading the high register. It also drives a result write and a low-byte read to one channel in the same cycle, which checks the ordering at that shared edge.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;
    localparam int CH_N    = 8;
    localparam int RES_W   = 10;
    localparam int BYTE_W  = 8;
    localparam int HI_W    = RES_W - BYTE_W;
    localparam int ADDR_W  = 4;
    localparam int CH_W    = $clog2(CH_N);
    localparam int HI_ADDR = CH_N;

    typedef logic [RES_W-1:0]  result_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [HI_W-1:0]   hi_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CH_W-1:0]   chan_t;

    typedef enum logic [1:0] {SEL_LOW, SEL_HIGH, SEL_NONE} sel_e;

    typedef struct packed {
        logic  rd;
        sel_e  sel;
        chan_t ch;
    } access_t;

    // Classify one bus access; write cycles never count as reads.
    function automatic access_t decode(input logic rd, input logic we, input addr_t a);
        access_t d;
        d.rd = rd & ~we;
        d.ch = a[CH_W-1:0];
        if (a < addr_t'(CH_N))
            d.sel = SEL_LOW;
        else if (a == addr_t'(HI_ADDR))
            d.sel = SEL_HIGH;
        else
            d.sel = SEL_NONE;
        return d;
    endfunction
endpackage

// File: rtl/adc_rb_store.sv
module adc_rb_store
    import adc_rb_pkg::*;
(
    input  logic    clk,
    input  logic    wr_en,
    input  chan_t   wr_ch,
    input  result_t wr_val,
    output result_t res_arr [CH_N]
);
    // Result storage is deliberately left without reset.
    for (genvar g = 0; g < CH_N; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (wr_en && wr_ch == chan_t'(g))
                res_arr[g] <= wr_val;
        end
    end
endmodule

// File: rtl/adc_rb_hold.sv
module adc_rb_hold
    import adc_rb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cap_en,
    input  hi_t  cap_val,
    output hi_t  hold
);
    always_ff @(posedge clk) begin
        if (rst)
            hold <= '0;
        else if (cap_en)
            hold <= cap_val;
    end
endmodule

// File: rtl/adc_rb_rdmux.sv
module adc_rb_rdmux
    import adc_rb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  access_t acc,
    input  byte_t   low_val,
    input  hi_t     hold,
    output byte_t   rdata
);
    byte_t nxt;

    always_comb begin
        unique case (acc.sel)
            SEL_LOW:  nxt = low_val;
            SEL_HIGH: nxt = {{(BYTE_W-HI_W){1'b0}}, hold};
            default:  nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (acc.rd)
            rdata <= nxt;
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              res_we,
    input  logic [CH_W-1:0]   res_ch,
    input  logic [RES_W-1:0]  res_data,
    input  logic              bus_rd,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_rdata
);
    access_t acc;
    result_t res_arr [CH_N];
    result_t sel_res;
    hi_t     hold_bits;
    logic    cap_en;

    assign acc     = decode(bus_rd, bus_we, bus_addr);
    assign sel_res = res_arr[acc.ch];
    assign cap_en  = acc.rd && (acc.sel == SEL_LOW);

    adc_rb_store u_store (
        .clk     (clk),
        .wr_en   (res_we),
        .wr_ch   (res_ch),
        .wr_val  (res_data),
        .res_arr (res_arr)
    );

    adc_rb_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .cap_val (sel_res[RES_W-1:BYTE_W]),
        .hold    (hold_bits)
    );

    adc_rb_rdmux u_rdmux (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .low_val (sel_res[BYTE_W-1:0]),
        .hold    (hold_bits),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/adc_rb_chk.sv
module adc_rb_chk
    import adc_rb_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  bus_rd,
    input logic  bus_we,
    input addr_t bus_addr,
    input byte_t bus_rdata,
    input hi_t   hold
);
    logic rd_ok;
    assign rd_ok = bus_rd && !bus_we;

    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
        !(rd_ok && bus_addr < addr_t'(CH_N)) |=> $stable(hold)); // R4

    AST_HIGH_FORMAT: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && bus_addr == addr_t'(HI_ADDR)) |=> bus_rdata == {{(BYTE_W-HI_W){1'b0}}, $past(hold)}); // R3

    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_we || !bus_rd) |=> $stable(bus_rdata)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (hold == '0 && bus_rdata == '0)); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && bus_addr > addr_t'(HI_ADDR)) |=> bus_rdata == '0); // R9
endmodule

bind adc_result_bank adc_rb_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .hold      (hold_bits)
);

// File: tb/test_adc_result_bank.sv
module test_adc_result_bank;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] VEC_VAL [8] = '{10'h3A5, 10'h17E, 10'h2C3, 10'h0FF,
                                           10'h300, 10'h1AA, 10'h255, 10'h000};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       res_we = 1'b0;
    logic [2:0] res_ch = '0;
    logic [9:0] res_data = '0;
    logic       bus_rd = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_rdata;

    int n_tests = 0;
    int n_fail = 0;
    logic [9:0] model [8];
    logic [7:0] got;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_result_bank i_adc_result_bank (
        .clk(clk), .rst(rst), .res_we(res_we), .res_ch(res_ch), .res_data(res_data),
        .bus_rd(bus_rd), .bus_we(bus_we), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic write_res(input int ch, input logic [9:0] v);
        @(negedge clk);
        res_we = 1'b1; res_ch = 3'(ch); res_data = v;
        @(negedge clk);
        res_we = 1'b0;
        model[ch] = v;
    endtask

    task automatic bus_read(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R7 rdata after reset", bus_rdata, 8'h00);
        bus_read(8, got);
        check("R7 hold after reset", got, 8'h00);

        // Table walk: load all channels, then read each pair
        for (int i = 0; i < 8; i++) write_res(i, VEC_VAL[i]);
        for (int i = 0; i < 8; i++) begin
            bus_read(i, got);
            check("R1 low byte", got, model[i][7:0]);
            bus_read(8, got);
            check("R2 R3 high byte", got, {6'b0, model[i][9:8]});
        end

        // R4: repeated high reads keep the latched bits
        bus_read(0, got);
        bus_read(8, got);
        check("R4 first high", got, 8'h03);
        bus_read(8, got);
        check("R4 second high", got, 8'h03);

        // R5: new result between low and high read
        write_res(0, 10'h0AB);
        bus_read(8, got);
        check("R5 high after write", got, 8'h03);
        bus_read(0, got);
        check("R5 new low", got, 8'hAB);
        bus_read(8, got);
        check("R5 new high", got, 8'h00);

        // R6: bus write is ignored
        bus_read(2, got);
        @(negedge clk);
        bus_rd = 1'b1; bus_we = 1'b1; bus_addr = 4'd3;
        @(negedge clk);
        bus_rd = 1'b0; bus_we = 1'b0;
        check("R6 rdata kept", bus_rdata, model[2][7:0]);
        bus_read(8, got);
        check("R6 hold kept", got, {6'b0, model[2][9:8]});
        bus_read(3, got);
        check("R6 storage kept", got, model[3][7:0]);

        // R8: same-cycle write and read of one channel
        @(negedge clk);
        res_we = 1'b1; res_ch = 3'd5; res_data = 10'h2F0;
        bus_rd = 1'b1; bus_addr = 4'd5;
        @(negedge clk);
        res_we = 1'b0; bus_rd = 1'b0;
        check("R8 old low", bus_rdata, 8'hAA);
        bus_read(8, got);
        check("R8 old high", got, 8'h01);
        model[5] = 10'h2F0;
        bus_read(5, got);
        check("R8 new low", got, 8'hF0);
        bus_read(8, got);
        check("R8 new high", got, 8'h02);

        // R9: unmapped addresses
        bus_read(12, got);
        check("R9 unmapped", got, 8'h00);
        bus_read(8, got);
        check("R9 hold kept", got, 8'h02);

        // R10: idle cycles keep read data
        repeat (3) @(negedge clk);
        check("R10 idle", bus_rdata, 8'h02);

        // R7: retention across reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R7 rdata cleared", bus_rdata, 8'h00);
        bus_read(8, got);
        check("R7 hold cleared", got, 8'h00);
        bus_read(1, got);
        check("R7 retained low", got, 8'h7E);
        bus_read(8, got);
        check("R7 retained high", got, 8'h01);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule